// File: doc/BRIEF.md
# Section-Carry Look-Ahead Adder

This block is a combinational two-operand binary adder. It takes two operands and a carry input, and it returns their sum together with a carry output. It has no clock and no state. The operands are split into fixed-width sections of four bits. Each section has one look-ahead network, and that network produces only the carry leaving the section. The network reads the section's generate and propagate terms and its incoming carry directly, and it does not wait on the bit carries inside the section. The carry from one section feeds the next section. The sum bits inside a section come from a short local ripple that starts at the section's incoming carry.

The block suits a datapath where a single-cycle sum is needed and the chain of section carries sets the timing path. It is not a full per-bit look-ahead tree, so it uses less logic. The operand width and the section width are parameters, and the section width must divide the operand width.

Top module: `sec_cla_adder`

## Requirements
- R1: For every input, `{carry_out, sum}` equals `opa + opb + carry_in` taken as an unsigned addition; with the defaults the operands are 32 bits wide.
- R2: The carry into section 0 is `carry_in`. The carry into section k+1 is the look-ahead carry of section k. `carry_out` is the look-ahead carry of the topmost section.
- R3: Each section carry equals the true arithmetic carry into bit position 4·(k+1) of the addition. It is formed in one look-ahead level from the section's generate bits (AND of operand bits), propagate bits (XOR of operand bits) and incoming carry.
- R4: Each sum bit is that bit's propagate term XORed with the carry into that bit. Inside a section, that carry ripples from the section's incoming carry.
- R5: When every bit propagates (`opa ^ opb` all ones), a carry input of 1 gives a zero sum with `carry_out` = 1, and a carry input of 0 gives an all-ones sum with `carry_out` = 0.
- R6: When the top bits of both operands are 1, `carry_out` is 1 whatever the other inputs are.
- R7: When `opa` is zero and `carry_in` is 0, `sum` equals `opb` and `carry_out` is 0.
- R8: The outputs are a pure function of the present inputs. A new input value shows up at the outputs without any clock edge, and earlier inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH (32) | First operand |
| opb | input | WIDTH (32) | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH (32) | Sum bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The checker compares the outputs and every internal section carry against the arithmetic result whenever the inputs change. It also checks the full-propagate, top-generate and zero-operand identities on every change. Only the bench's scenarios can show that an output depends only on the present inputs, that is, that no earlier vector leaks into a later result. The bench drives a fixed table of carry-chain patterns and then random vectors. Its expected values come from the requirements and from the language's own addition.

// File: rtl/sec_cla_pkg.sv
package sec_cla_pkg;
  localparam int unsigned DEF_WIDTH = 32;
  localparam int unsigned DEF_SEC_W = 4;

  // Number of sections for a given operand and section width.
  function automatic int unsigned num_sections(int unsigned w, int unsigned s);
    return w / s;
  endfunction
endpackage

// File: rtl/sec_cla_pg.sv
// Per-bit propagate and generate terms for one section.
module sec_cla_pg #(
  parameter int unsigned SEC_W = 4
) (
  input  logic [SEC_W-1:0] a_i,
  input  logic [SEC_W-1:0] b_i,
  output logic [SEC_W-1:0] p_o,
  output logic [SEC_W-1:0] g_o
);
  for (genvar i = 0; i < SEC_W; i++) begin : g_bit
    assign p_o[i] = a_i[i] ^ b_i[i];
    assign g_o[i] = a_i[i] & b_i[i];
  end
endmodule

// File: rtl/sec_cla_lookahead.sv
// One carry per section, computed in a single sum-of-products level.
module sec_cla_lookahead #(
  parameter int unsigned SEC_W = 4
) (
  input  logic [SEC_W-1:0] p_i,
  input  logic [SEC_W-1:0] g_i,
  input  logic             c_i,
  output logic             c_o
);
  logic [SEC_W-1:0] term;

  always_comb begin
    for (int j = 0; j < SEC_W; j++) begin
      term[j] = g_i[j];
      for (int k = j + 1; k < SEC_W; k++) begin
        term[j] = term[j] & p_i[k];
      end
    end
  end

  assign c_o = (|term) | ((&p_i) & c_i);
endmodule

// File: rtl/sec_cla_section.sv
// One section: pg terms, local ripple for the sum bits, look-ahead carry out.
module sec_cla_section #(
  parameter int unsigned SEC_W = 4
) (
  input  logic [SEC_W-1:0] a_i,
  input  logic [SEC_W-1:0] b_i,
  input  logic             c_i,
  output logic [SEC_W-1:0] s_o,
  output logic             c_o
);
  logic [SEC_W-1:0] p;
  logic [SEC_W-1:0] g;
  logic [SEC_W-1:0] bit_c;

  sec_cla_pg #(.SEC_W(SEC_W)) u_pg (
    .a_i (a_i),
    .b_i (b_i),
    .p_o (p),
    .g_o (g)
  );

  // Local ripple only as far as the last sum bit; the section carry comes
  // from the look-ahead network below, not from this chain.
  always_comb begin
    bit_c[0] = c_i;
    for (int i = 1; i < SEC_W; i++) begin
      bit_c[i] = g[i-1] | (p[i-1] & bit_c[i-1]);
    end
  end

  assign s_o = p ^ bit_c;

  sec_cla_lookahead #(.SEC_W(SEC_W)) u_la (
    .p_i (p),
    .g_i (g),
    .c_i (c_i),
    .c_o (c_o)
  );
endmodule

// File: rtl/sec_cla_adder.sv
module sec_cla_adder
  import sec_cla_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned SEC_W = DEF_SEC_W
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int unsigned NSEC = num_sections(WIDTH, SEC_W);

  logic [NSEC:0] sec_carry;

  assign sec_carry[0] = carry_in;

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    sec_cla_section #(.SEC_W(SEC_W)) u_sec (
      .a_i (opa[k*SEC_W +: SEC_W]),
      .b_i (opb[k*SEC_W +: SEC_W]),
      .c_i (sec_carry[k]),
      .s_o (sum[k*SEC_W +: SEC_W]),
      .c_o (sec_carry[k+1])
    );
  end

  assign carry_out = sec_carry[NSEC];
endmodule

// File: rtl/sec_cla_adder_chk.sv
module sec_cla_adder_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned SEC_W = 4
) (
  input logic [WIDTH-1:0]       opa,
  input logic [WIDTH-1:0]       opb,
  input logic                   carry_in,
  input logic [WIDTH-1:0]       sum,
  input logic                   carry_out,
  input logic [WIDTH/SEC_W:0]   sec_carry
);
  localparam int unsigned NSEC = WIDTH / SEC_W;

  logic [WIDTH:0] ref_total;
  logic           known;

  assign ref_total = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, carry_in};
  assign known     = !$isunknown({opa, opb, carry_in, sum, carry_out, sec_carry});

  always_comb begin
    if (known) begin
      p_total_r1: assert ({carry_out, sum} == ref_total);
      p_first_carry_r2: assert (sec_carry[0] == carry_in);
      p_last_carry_r2: assert (sec_carry[NSEC] == carry_out);
      for (int k = 1; k < NSEC; k++) begin
        // R3: carry into bit k*SEC_W recovered from the reference sum
        p_sec_carry_r3: assert (sec_carry[k] ==
          (ref_total[k*SEC_W] ^ opa[k*SEC_W] ^ opb[k*SEC_W]));
      end
      if ((&(opa ^ opb)) && carry_in)
        p_prop_one_r5: assert ((sum == '0) && carry_out);
      if ((&(opa ^ opb)) && !carry_in)
        p_prop_zero_r5: assert ((&sum) && !carry_out);
      if (opa[WIDTH-1] && opb[WIDTH-1])
        p_top_gen_r6: assert (carry_out);
      if ((opa == '0) && !carry_in)
        p_zero_id_r7: assert ((sum == opb) && !carry_out);
    end
  end
endmodule

bind sec_cla_adder sec_cla_adder_chk #(.WIDTH(WIDTH), .SEC_W(SEC_W)) u_chk (
  .opa       (opa),
  .opb       (opb),
  .carry_in  (carry_in),
  .sum       (sum),
  .carry_out (carry_out),
  .sec_carry (sec_carry)
);

// File: tb/tb_sec_cla_adder.sv
`timescale 1ns/1ps
module tb_sec_cla_adder;
  logic        clk;
  logic        rst_n;
  logic [31:0] opa;
  logic [31:0] opb;
  logic        carry_in;
  logic [31:0] sum;
  logic        carry_out;

  int checks = 0;
  int fails  = 0;

  sec_cla_adder dut (
    .opa       (opa),
    .opb       (opb),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        ci;
    logic [31:0] s;
    logic        co;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 1'b1}, // R5 propagate + cin
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF, 1'b1}, // R1 max
    '{32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 32'hFFFF_FFFF, 1'b0}, // R5 no cin
    '{32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 32'h0000_0000, 1'b1}, // R5 full chain
    '{32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0}, // R7 zero
    '{32'h0000_000F, 32'h0000_0001, 1'b0, 32'h0000_0010, 1'b0}, // R3 section 0 carry
    '{32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1}, // R6 top generate
    '{32'h1234_5678, 32'h1111_1111, 1'b0, 32'h2345_6789, 1'b0}, // R4 no carries
    '{32'h0FFF_FFFF, 32'h0000_0001, 1'b0, 32'h1000_0000, 1'b0}, // R2 chain to section 7
    '{32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 32'h8000_0000, 1'b0}, // R4 top bit via ripple
    '{32'h0000_0000, 32'hDEAD_BEEF, 1'b0, 32'hDEAD_BEEF, 1'b0}  // R7 identity
  };

  task automatic check(input string rq, input logic [31:0] es, input logic eco);
    checks++;
    if ({carry_out, sum} !== {eco, es}) begin
      fails++;
      $display("FAIL %s: got cout=%0b sum=%08h, expected cout=%0b sum=%08h",
               rq, carry_out, sum, eco, es);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic ci);
    @(negedge clk);
    opa = a;
    opb = b;
    carry_in = ci;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1: got hung run, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [32:0] ref_v;
    logic [31:0] ra;
    logic [31:0] rb;
    logic        rc;
    opa = '0;
    opb = '0;
    carry_in = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset state: zero inputs give zero outputs (R7)
    apply(32'h0, 32'h0, 1'b0);
    check("R7 reset", 32'h0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i].a, VEC[i].b, VEC[i].ci);
      check("R1 table", VEC[i].s, VEC[i].co);
    end

    // R8: change inputs mid-cycle, no clock edge in between
    @(negedge clk);
    opa = 32'hFFFF_FFFF; opb = 32'h0; carry_in = 1'b1;
    #0.5;
    check("R8 first", 32'h0, 1'b1);
    opa = 32'h0000_0001; opb = 32'h0000_0001; carry_in = 1'b0;
    #0.5;
    check("R8 second", 32'h0000_0002, 1'b0);

    // R2/R3: carry generated in each section and propagated through the rest
    for (int k = 0; k < 8; k++) begin
      apply(32'hFFFF_FFFF << (4*k), 32'h1 << (4*k), 1'b0);
      check("R3 section carry", 32'h0, 1'b1);
    end

    // R6: top generate with arbitrary low bits
    apply(32'h8123_4567, 32'h8765_4321, 1'b1);
    check("R6 top generate", 32'h0888_8889, 1'b1);

    // Random vectors against the built-in addition (R1, R4)
    for (int n = 0; n < 400; n++) begin
      ra = $urandom;
      rb = $urandom;
      rc = 1'($urandom);
      ref_v = {1'b0, ra} + {1'b0, rb} + {32'b0, rc};
      apply(ra, rb, rc);
      check("R1 random", ref_v[31:0], ref_v[32]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule